// File: doc/BRIEF.md
# Password-Gated Copy Authorizer

This block decides whether a scratchpad-to-memory copy may run, and it answers password verification requests. It works at byte level. The first byte after a bus reset is the command. For a copy, the master then echoes the three address registers, TA1, TA2 and the ending-offset/status byte. After that it sends an 8-byte password.

The password is enforced only while the control byte holds AAh. With any other control value, every 8-byte pattern is accepted. When both checks pass, the block pulses the authorization-accepted flag. It holds a copy request toward the memory model for a fixed number of clock cycles, as long as power stays good. After that it answers every read with an alternating bit pattern. A refused or interrupted copy answers FFh until the next bus reset.

For verification, the block takes a two-byte address and an 8-byte candidate. It answers AAh on a match and FFh otherwise. The stored value itself is never returned.

Top module: `copy_authorizer`

## Requirements
- R1: After `rst` or a `bus_reset` pulse, `copy_req` and `aa_set` are low, and each read returns FFh.
- R2: Command 99h, followed by bytes equal to `ta1`, `ta2` and `es` (in that order) and then 8 further bytes, starts a copy when the checks pass. In that case `aa_set` pulses once, and `copy_req` stays high for exactly COPY_CYCLES cycles. `copy_addr` = {ta2,ta1} and `copy_end` = es[5:0].
- R3: If any of the three echoed bytes differs from the register it echoes, no copy starts (`copy_req` and `aa_set` stay low), and reads return FFh.
- R4: With `pw_ctrl` = AAh, received password byte k (k = 0 first) is compared with `pw_full[8k+7:8k]`. A single differing byte refuses the copy; an exact match allows it.
- R5: With `pw_ctrl` other than AAh, any 8-byte pattern is accepted as the password.
- R6: After a completed copy, every read returns 55h: bit 0 is 1 and bits alternate, and bits are read LSB first.
- R7: If `pwr_good` is low in any cycle of the copy window, `copy_req` drops in the next cycle, and reads return FFh until a bus reset.
- R8: Command C3h takes the address low byte then high byte, with address bits 2:0 ignored, followed by 8 bytes. Address 7FC0h compares against `pw_read`, and address 7FC8h compares against `pw_full`. Every following read returns AAh on a full match and FFh otherwise. Verification never raises `copy_req` or `aa_set`.
- R9: A verify request to any address other than the two password slots returns FFh.
- R10: A command byte other than 99h or C3h starts nothing, and reads return FFh until a bus reset.
- R11: `tx_valid` pulses in the cycle after each `rd_req` cycle, carrying `tx_data`.
- R12: A `bus_reset` during the copy window drops `copy_req` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset pulse; returns to command phase |
| rx_valid | input | 1 | Byte from master valid |
| rx_data | input | 8 | Byte from master |
| rd_req | input | 1 | Master requests one byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| ta1 | input | 8 | Target address low register |
| ta2 | input | 8 | Target address high register |
| es | input | 8 | Ending offset / status register |
| pw_ctrl | input | 8 | Password control byte (AAh enables checking) |
| pw_read | input | 64 | Stored read-access password |
| pw_full | input | 64 | Stored read/write password |
| pwr_good | input | 1 | Supply adequate during copy |
| copy_req | output | 1 | Copy in progress toward memory model |
| aa_set | output | 1 | One-cycle pulse: authorization accepted |
| copy_addr | output | 16 | Captured target address |
| copy_end | output | 6 | Captured ending offset |

## Verification
A byte sent at one edge becomes decision state at that same edge. `aa_set` and `copy_req` are therefore visible at the falling edge right after the last password byte. A read reply appears one cycle after `rd_req`. The bench drives each byte or request for exactly one rising edge and samples at the following falling edge. It counts the falling edges on which `copy_req` is high and compares that count with COPY_CYCLES. A power drop or bus reset is checked one falling edge after it is applied.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam logic [7:0] CMD_COPY   = 8'h99;
  localparam logic [7:0] CMD_VERIFY = 8'hC3;
  localparam logic [7:0] PW_ARMED   = 8'hAA;
  localparam logic [7:0] REPLY_OK   = 8'h55;
  localparam logic [7:0] REPLY_HIT  = 8'hAA;
  localparam logic [7:0] REPLY_IDLE = 8'hFF;

  typedef enum logic [3:0] {
    ST_CMD, ST_AUTH, ST_CPW, ST_COPY, ST_DONE, ST_DEAD, ST_VADR, ST_VPW, ST_VRES
  } cpa_state_t;
endpackage

// File: rtl/cpa_pw_compare.sv
module cpa_pw_compare #(
  parameter int PW_BYTES = 8,
  localparam int IW = $clog2(PW_BYTES),
  localparam int PW_W = 8 * PW_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic [7:0]      din,
  input  logic [PW_W-1:0] ref_pw,
  output logic            last_byte,
  output logic            miss_any
);
  logic [IW-1:0] idx_q;
  logic          miss_q;
  logic          diff;

  always_comb begin
    diff      = en && (din != ref_pw[{idx_q, 3'b000} +: 8]);
    last_byte = (idx_q == IW'(PW_BYTES - 1));
    miss_any  = miss_q | diff;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else if (en) begin
      idx_q  <= idx_q + 1'b1;
      miss_q <= miss_q | diff;
    end
  end

  // R4: a mismatch, once seen, persists until the compare is cleared
  a_r4_sticky_miss: assert property (@(posedge clk) disable iff (rst)
    (miss_q && !clr) |=> miss_q);
endmodule

// File: rtl/cpa_copy_timer.sv
module cpa_copy_timer #(
  parameter int CYCLES = 1000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_comb done = active && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  // R2: the window counter never passes its last cycle
  a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CYCLES - 1));
endmodule

// File: rtl/copy_authorizer.sv
module copy_authorizer
  import cpa_pkg::*;
#(
  parameter int          PW_BYTES    = 8,
  parameter int          COPY_CYCLES = 1000,
  parameter int          OFF_W       = 6,
  parameter logic [15:0] PW_BASE     = 16'h7FC0,
  localparam int         PW_W        = 8 * PW_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rd_req,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic [7:0]       ta1,
  input  logic [7:0]       ta2,
  input  logic [7:0]       es,
  input  logic [7:0]       pw_ctrl,
  input  logic [PW_W-1:0]  pw_read,
  input  logic [PW_W-1:0]  pw_full,
  input  logic             pwr_good,
  output logic             copy_req,
  output logic             aa_set,
  output logic [15:0]      copy_addr,
  output logic [OFF_W-1:0] copy_end
);
  cpa_state_t     st;
  logic [1:0]     step_q;
  logic           auth_bad_q;
  logic [15:3]    vaddr_q;
  logic [7:0]     vreply_q;
  logic [7:0]     auth_exp;
  logic           auth_bad_now;
  logic           pw_en, pw_clr, pw_last, pw_miss;
  logic [PW_W-1:0] pw_ref;
  logic           slot_ok;
  logic           copy_done;

  always_comb begin
    case (step_q)
      2'd0:    auth_exp = ta1;
      2'd1:    auth_exp = ta2;
      default: auth_exp = es;
    endcase
    auth_bad_now = auth_bad_q | (rx_data != auth_exp);
    pw_en   = rx_valid && (st == ST_CPW || st == ST_VPW);
    pw_clr  = bus_reset || (st == ST_CMD);
    pw_ref  = (st == ST_VPW && !vaddr_q[3]) ? pw_read : pw_full;
    slot_ok = (vaddr_q[15:4] == PW_BASE[15:4]);
  end

  cpa_pw_compare #(.PW_BYTES(PW_BYTES)) u_cmp (
    .clk(clk), .rst(rst), .clr(pw_clr), .en(pw_en), .din(rx_data),
    .ref_pw(pw_ref), .last_byte(pw_last), .miss_any(pw_miss)
  );

  cpa_copy_timer #(.CYCLES(COPY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .active(st == ST_COPY), .done(copy_done)
  );

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      st         <= ST_CMD;
      step_q     <= '0;
      auth_bad_q <= 1'b0;
      vaddr_q    <= '0;
      vreply_q   <= REPLY_IDLE;
      copy_req   <= 1'b0;
      aa_set     <= 1'b0;
      if (rst) begin
        copy_addr <= '0;
        copy_end  <= '0;
      end
    end else begin
      aa_set <= 1'b0;
      case (st)
        ST_CMD: if (rx_valid) begin
          step_q     <= '0;
          auth_bad_q <= 1'b0;
          if (rx_data == CMD_COPY)        st <= ST_AUTH;
          else if (rx_data == CMD_VERIFY) st <= ST_VADR;
          else                            st <= ST_DEAD;
        end
        ST_AUTH: if (rx_valid) begin
          auth_bad_q <= auth_bad_now;
          step_q     <= step_q + 1'b1;
          if (step_q == 2'd2) st <= ST_CPW;
        end
        ST_CPW: if (rx_valid && pw_last) begin
          if (!auth_bad_q && (pw_ctrl != PW_ARMED || !pw_miss)) begin
            st        <= ST_COPY;
            copy_req  <= 1'b1;
            aa_set    <= 1'b1;
            copy_addr <= {ta2, ta1};
            copy_end  <= es[OFF_W-1:0];
          end else begin
            st <= ST_DEAD;
          end
        end
        ST_COPY: begin
          if (!pwr_good) begin
            st       <= ST_DEAD;
            copy_req <= 1'b0;
          end else if (copy_done) begin
            st       <= ST_DONE;
            copy_req <= 1'b0;
          end
        end
        ST_VADR: if (rx_valid) begin
          step_q <= step_q + 1'b1;
          if (step_q == 2'd0) vaddr_q[7:3] <= rx_data[7:3];
          else begin
            vaddr_q[15:8] <= rx_data;
            st            <= ST_VPW;
          end
        end
        ST_VPW: if (rx_valid && pw_last) begin
          vreply_q <= (slot_ok && !pw_miss) ? REPLY_HIT : REPLY_IDLE;
          st       <= ST_VRES;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= REPLY_IDLE;
    end else begin
      tx_valid <= rd_req;
      if (rd_req) begin
        case (st)
          ST_DONE: tx_data <= REPLY_OK;
          ST_VRES: tx_data <= vreply_q;
          default: tx_data <= REPLY_IDLE;
        endcase
      end
    end
  end

  // R2: acceptance pulse only coincides with an active copy window
  a_r2_aa_with_copy: assert property (@(posedge clk) disable iff (rst)
    aa_set |-> copy_req);
  // R2: captured target address holds while copying
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (copy_req && !aa_set) |-> $stable(copy_addr));
  // R7: power loss ends the copy on the next cycle
  a_r7_power_drop: assert property (@(posedge clk) disable iff (rst)
    (copy_req && !pwr_good) |=> !copy_req);
  // R12: bus reset ends the copy on the next cycle
  a_r12_reset_drop: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (!copy_req && !aa_set));
  // R11: one reply per request, one cycle later
  a_r11_reply_timing: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> tx_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !tx_valid);
endmodule

// File: tb/sim_copy_authorizer.sv
`timescale 1ns/1ps
module sim_copy_authorizer;
  localparam int CYC = 16;

  logic clk = 1'b0;
  logic rst, bus_reset, rx_valid, rd_req, pwr_good;
  logic [7:0] rx_data, ta1, ta2, es, pw_ctrl, tx_data;
  logic [63:0] pw_read, pw_full;
  logic tx_valid, copy_req, aa_set;
  logic [15:0] copy_addr;
  logic [5:0] copy_end;

  int n_chk = 0, n_bad = 0;
  int aa_cnt = 0;
  bit seen_copy = 0;

  always #2.5 clk = ~clk;

  copy_authorizer #(.COPY_CYCLES(CYC)) u0 (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_data(rx_data), .rd_req(rd_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .ta1(ta1), .ta2(ta2), .es(es), .pw_ctrl(pw_ctrl), .pw_read(pw_read),
    .pw_full(pw_full), .pwr_good(pwr_good), .copy_req(copy_req),
    .aa_set(aa_set), .copy_addr(copy_addr), .copy_end(copy_end)
  );

  always @(negedge clk) begin
    if (copy_req) seen_copy = 1;
    if (aa_set) aa_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read(output logic [7:0] b, output logic v);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    b = tx_data; v = tx_valid;
  endtask

  task automatic breset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    seen_copy = 0; aa_cnt = 0;
  endtask

  task automatic send_pw(input logic [63:0] p);
    for (int k = 0; k < 8; k++) send(p[8*k +: 8]);
  endtask

  task automatic copy_seq(input logic [7:0] a1, input logic [7:0] a2,
                          input logic [7:0] e, input logic [63:0] p);
    send(8'h99); send(a1); send(a2); send(e); send_pw(p);
  endtask

  task automatic t_reset_state();
    logic [7:0] b; logic v;
    check("R1 copy_req after rst", copy_req, 0);
    check("R1 aa_set after rst", aa_set, 0);
    read(b, v);
    check("R11 tx_valid", v, 1);
    check("R1 idle reply", b, 8'hFF);
  endtask

  task automatic t_copy_open();
    logic [7:0] b; logic v; int n;
    breset();
    pw_ctrl = 8'h00;
    copy_seq(ta1, ta2, es, 64'h0123_4567_89AB_CDEF);
    check("R5 aa_set pulse", aa_set, 1);
    check("R2 copy_req up", copy_req, 1);
    check("R2 copy_addr", copy_addr, {ta2, ta1});
    check("R2 copy_end", copy_end, es[5:0]);
    n = 0;
    while (copy_req && n < 1000) begin n++; @(negedge clk); end
    check("R2 window length", n, CYC);
    check("R2 single aa pulse", aa_cnt, 1);
    read(b, v);
    check("R6 success pattern", b, 8'h55);
    read(b, v);
    check("R6 success pattern again", b, 8'h55);
  endtask

  task automatic t_auth_bad();
    logic [7:0] b; logic v;
    breset();
    pw_ctrl = 8'h00;
    copy_seq(ta1, ta2, es ^ 8'h01, 64'h0);
    repeat (3) @(negedge clk);
    check("R3 no copy on bad echo", seen_copy, 0);
    check("R3 no aa on bad echo", aa_cnt, 0);
    read(b, v);
    check("R3 fail reply", b, 8'hFF);
    breset();
    copy_seq(ta1 ^ 8'h80, ta2, es, 64'h0);
    repeat (3) @(negedge clk);
    check("R3 no copy on bad ta1", seen_copy, 0);
  endtask

  task automatic t_password();
    logic [7:0] b; logic v;
    breset();
    pw_ctrl = 8'hAA;
    copy_seq(ta1, ta2, es, pw_full ^ 64'h0100_0000_0000_0000);
    repeat (3) @(negedge clk);
    check("R4 wrong last byte refused", seen_copy, 0);
    read(b, v);
    check("R4 refused reply", b, 8'hFF);
    breset();
    copy_seq(ta1, ta2, es, pw_full ^ 64'h1);
    repeat (3) @(negedge clk);
    check("R4 wrong first byte refused", seen_copy, 0);
    breset();
    copy_seq(ta1, ta2, es, pw_full);
    check("R4 right password accepted", aa_set, 1);
    while (copy_req) @(negedge clk);
    read(b, v);
    check("R4 success reply", b, 8'h55);
    breset();
    copy_seq(ta1, ta2, es, pw_read);
    repeat (3) @(negedge clk);
    check("R4 read password not valid for copy", seen_copy, 0);
  endtask

  task automatic t_power_fail();
    logic [7:0] b; logic v;
    breset();
    pw_ctrl = 8'h00;
    copy_seq(ta1, ta2, es, 64'h0);
    repeat (3) @(negedge clk);
    check("R7 still copying", copy_req, 1);
    pwr_good = 1'b0;
    @(negedge clk);
    check("R7 copy dropped", copy_req, 0);
    pwr_good = 1'b1;
    repeat (CYC) @(negedge clk);
    read(b, v);
    check("R7 fail reply", b, 8'hFF);
    read(b, v);
    check("R7 fail reply persists", b, 8'hFF);
  endtask

  task automatic t_bus_reset_copy();
    logic [7:0] b; logic v;
    breset();
    copy_seq(ta1, ta2, es, 64'h0);
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check("R12 copy dropped on bus reset", copy_req, 0);
    read(b, v);
    check("R1 idle after bus reset", b, 8'hFF);
  endtask

  task automatic verify(input logic [15:0] a, input logic [63:0] p, input logic [7:0] exp, input string tag);
    logic [7:0] b; logic v;
    breset();
    send(8'hC3); send(a[7:0]); send(a[15:8]); send_pw(p);
    read(b, v);
    check(tag, b, exp);
    read(b, v);
    check(tag, b, exp);
    check("R8 verify starts no copy", seen_copy, 0);
  endtask

  task automatic t_verify();
    pw_ctrl = 8'hAA;
    verify(16'h7FC0, pw_read, 8'hAA, "R8 read slot match");
    verify(16'h7FC5, pw_read, 8'hAA, "R8 low bits ignored");
    verify(16'h7FC8, pw_full, 8'hAA, "R8 full slot match");
    verify(16'h7FC8, pw_read, 8'hFF, "R8 full slot mismatch");
    verify(16'h7FC0, pw_read ^ 64'h0080_0000_0000_0000, 8'hFF, "R8 one byte off");
    verify(16'h1000, pw_read, 8'hFF, "R9 non-password address");
  endtask

  task automatic t_unknown();
    logic [7:0] b; logic v;
    breset();
    send(8'h0F);
    copy_seq(ta1, ta2, es, 64'h0);
    repeat (3) @(negedge clk);
    check("R10 no copy after unknown command", seen_copy, 0);
    read(b, v);
    check("R10 unknown reply", b, 8'hFF);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_reset = 1'b0; rx_valid = 1'b0; rd_req = 1'b0;
    rx_data = 8'h00; pwr_good = 1'b1; pw_ctrl = 8'h00;
    ta1 = 8'h3C; ta2 = 8'h10; es = 8'h3F;
    pw_read = 64'h1122_3344_5566_7788;
    pw_full = 64'hA1B2_C3D4_E5F6_0718;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_copy_open();
    t_auth_bad();
    t_password();
    t_power_fail();
    t_bus_reset_copy();
    t_verify();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule